// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block frees a two-wire serial bus that a target has left stuck with its data line held low. When it accepts a start request it takes both lines over through two open-drain override enables and first clocks the bus nine times. Each of these clock periods releases both lines for one step and then pulls the clock line low for one step. It then builds a STOP condition by hand. The clock and data lines are both pulled low, the clock line is released while data stays low, and finally data is released while the clock line is high.

Every step is held for a programmable number of system clocks. For a 50 MHz clock and a nominal 5 µs step this is 250. While a sequence runs the block reports busy. One cycle after the last step it raises a single-cycle done pulse. When idle it drives neither override, so the normal transfer engine owns the lines. The live levels of both lines pass through a two-flop synchronizer and are presented for software to read.

Top module: `twowire_recovery`

## Requirements
- R1: After reset, busy, done and both override enables are 0, and the synchronized line levels read 2'b11.
- R2: A start request that is high at a clock edge while idle sets busy at that edge, and the sequence begins with its first step.
- R3: The first 18 steps form nine clock periods. Each period has one step with both overrides off, followed by one step with only the clock override on. The data override stays off throughout, so the clock override rises exactly nine times.
- R4: After the clock periods come three more steps: both overrides on, then only the data override on, then both off. The data override therefore rises only while the clock override is on and falls only while the clock override is off.
- R5: Every step lasts exactly STEP_CLKS clock cycles, so busy stays high for 21 × STEP_CLKS cycles.
- R6: busy falls at the edge that ends the last step, and done is high for exactly that one following cycle.
- R7: A start request that arrives while busy is ignored: the running sequence keeps its step and timing, and no second sequence follows.
- R8: Whenever busy is low, both override enables are 0.
- R9: levels_o holds {clock line, data line} (bit 1 is the clock line, bit 0 is the data line). It follows the inputs with a latency of two clock edges.
- R10: A new start request accepted in the cycle that done is high begins a fresh sequence at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to run one recovery sequence |
| scl_in | input | 1 | Live level of the clock line |
| sda_in | input | 1 | Live level of the data line |
| scl_pull_o | output | 1 | 1 pulls the clock line low |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the last step |
| levels_o | output | 2 | Synchronized levels {clock, data} |

## Verification
The bench builds two copies of the block side by side. One uses a step length of four clocks, so a full 21-step run completes in under a hundred cycles and an ignored mid-step request lands well inside a step. The other uses a step length of one clock, the smallest legal value. In that copy every cycle is a step boundary, which tests whether the counter wraps correctly and whether a new step begins on every edge. With the default of 250 clocks the same checks would need over five thousand cycles per run and would not exercise the single-cycle boundary.

// File: rtl/twowire_recovery.sv
module twowire_recovery #(
  parameter int STEP_CLKS = 250,
  parameter int PULSES    = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_pull_o,
  output logic       sda_pull_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] levels_o
);
  localparam int CNT_W  = $clog2(STEP_CLKS + 1);
  localparam int TRAIN  = 2 * PULSES;
  localparam int STEPS  = TRAIN + 3;
  localparam int STEP_W = $clog2(STEPS + 1);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(STEP_CLKS - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);
  localparam logic [STEP_W-1:0] STEP_BOTH = STEP_W'(TRAIN);
  localparam logic [STEP_W-1:0] STEP_SDA  = STEP_W'(TRAIN + 1);

  logic              busy_q, done_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [STEP_W-1:0] step_q;
  logic [1:0]        meta_q, live_q;
  logic              step_end;
  logic              scl_pull, sda_pull;

  assign step_end = busy_q && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      step_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          step_q <= '0;
        end
      end else if (step_end) begin
        cnt_q <= '0;
        if (step_q == STEP_LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    scl_pull = 1'b0;
    sda_pull = 1'b0;
    if (busy_q) begin
      if (step_q < STEP_BOTH) begin
        scl_pull = step_q[0];
      end else if (step_q == STEP_BOTH) begin
        scl_pull = 1'b1;
        sda_pull = 1'b1;
      end else if (step_q == STEP_SDA) begin
        sda_pull = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 2'b11;
      live_q <= 2'b11;
    end else begin
      meta_q <= {scl_in, sda_in};
      live_q <= meta_q;
    end
  end

  assign scl_pull_o = scl_pull;
  assign sda_pull_o = sda_pull;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign levels_o   = live_q;

  assert_begin_first_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (step_q == '0 && cnt_q == '0));

  assert_sda_falls_under_low_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> scl_pull_o);

  assert_sda_release_is_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_o) |-> !scl_pull_o);

  assert_step_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cnt_q <= CNT_LAST);

  assert_done_with_busy_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $fell(busy_q));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !step_end) |=> (busy_q && $stable(step_q)));
endmodule

// File: tb/twowire_recovery_test.sv
`timescale 1ns/1ps
module twowire_recovery_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_a = 1'b0, start_b = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic scl_a, sda_a, busy_a, done_a;
  logic scl_b, sda_b, busy_b, done_b;
  logic [1:0] lv_a, lv_b;
  logic sel = 1'b0;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  twowire_recovery #(.STEP_CLKS(4)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_a), .scl_in(scl_in), .sda_in(sda_in),
    .scl_pull_o(scl_a), .sda_pull_o(sda_a), .busy_o(busy_a), .done_o(done_a), .levels_o(lv_a));

  twowire_recovery #(.STEP_CLKS(1)) uut_one (
    .clk(clk), .rst_n(rst_n), .start_i(start_b), .scl_in(scl_in), .sda_in(sda_in),
    .scl_pull_o(scl_b), .sda_pull_o(sda_b), .busy_o(busy_b), .done_o(done_b), .levels_o(lv_b));

  wire scl_s  = sel ? scl_b  : scl_a;
  wire sda_s  = sel ? sda_b  : sda_a;
  wire busy_s = sel ? busy_b : busy_a;
  wire done_s = sel ? done_b : done_a;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_start(input bit v);
    if (sel) start_b = v; else start_a = v;
  endtask

  function automatic void pattern(input int step, output bit s, output bit d);
    if (step < 18) begin s = step[0]; d = 1'b0; end
    else if (step == 18) begin s = 1'b1; d = 1'b1; end
    else if (step == 19) begin s = 1'b0; d = 1'b1; end
    else begin s = 1'b0; d = 1'b0; end
  endfunction

  task automatic t_reset();
    check("R1 busy", busy_a, 0);
    check("R1 done", done_a, 0);
    check("R1 pulls", {scl_a, sda_a, scl_b, sda_b}, 0);
    check("R1 levels", lv_a, 2'b11);
  endtask

  task automatic run_seq(input bit which, input int s, input bit poke, input bit chain);
    int e3 = 0, e4 = 0, e5 = 0, e6 = 0, e8 = 0, rises = 0;
    bit es, ed, prev_scl = 1'b0;
    sel = which;
    @(negedge clk);
    if (!chain) check("R8 idle pulls before start", {scl_s, sda_s}, 0);
    check("R2 idle before start", busy_s, 0);
    set_start(1'b1);
    @(negedge clk);
    set_start(1'b0);
    check("R2 busy after start", busy_s, 1);
    for (int i = 0; i <= 21 * s + 3; i++) begin
      if (poke && i == 5) set_start(1'b1);
      if (poke && i == 6) set_start(1'b0);
      if (i < 21 * s) begin
        pattern(i / s, es, ed);
        if (busy_s !== 1'b1) e5++;
        if (done_s !== 1'b0) e6++;
        if (i / s < 18) begin
          if (scl_s !== es || sda_s !== ed) e3++;
        end else if (scl_s !== es || sda_s !== ed) e4++;
        if (scl_s && !prev_scl) rises++;
        prev_scl = scl_s;
      end else if (i == 21 * s) begin
        if (busy_s !== 1'b0) e5++;
        if (done_s !== 1'b1) e6++;
        if (scl_s || sda_s) e8++;
      end else begin
        if (busy_s || done_s) begin e6++; if (poke) e6++; end
        if (scl_s || sda_s) e8++;
      end
      @(negedge clk);
    end
    check("R3 train pattern mismatches", e3, 0);
    check("R3 clock override rises", rises, 9);
    check("R4 stop tail mismatches", e4, 0);
    check("R5 busy length mismatches", e5, 0);
    check("R6 done pulse mismatches", e6, 0);
    check("R8 idle overrides after end", e8, 0);
    if (poke) check("R7 no second sequence", busy_s, 0);
  endtask

  task automatic t_chain();
    sel = 1'b1;
    @(negedge clk);
    set_start(1'b1);
    while (!done_b) @(negedge clk);
    check("R10 done seen with start held", done_b, 1);
    @(negedge clk);
    set_start(1'b0);
    check("R10 restarted after done", busy_b, 1);
    check("R10 first step releases lines", {scl_b, sda_b}, 0);
    repeat (22) @(negedge clk);
  endtask

  task automatic t_levels();
    @(negedge clk);
    scl_in = 1'b1; sda_in = 1'b0;
    @(negedge clk);
    check("R9 one edge latency", lv_a, 2'b11);
    @(negedge clk);
    check("R9 data low", lv_a, 2'b10);
    scl_in = 1'b0; sda_in = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R9 clock low", lv_b, 2'b01);
    scl_in = 1'b1; sda_in = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R9 both high", lv_a, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_seq(1'b0, 4, 1'b0, 1'b0);
    run_seq(1'b1, 1, 1'b0, 1'b0);
    run_seq(1'b0, 4, 1'b1, 1'b0);
    run_seq(1'b1, 1, 1'b1, 1'b0);
    t_chain();
    t_levels();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule